// File: doc/BRIEF.md
# Timer Event Status Flags

This block holds the interrupt status flags of a 16-bit timer. It is one 8-bit register. It records a counter wrap event and one event per channel for four channels. A channel event is a compare match or an input capture on that channel's general register. The timer core delivers each event as a single-cycle strobe. The register only holds and clears the flags; it has no counter and no compare or capture logic.

Software sees the register through a small bus: a select, a read strobe, a write strobe and 8 bits of write data. Read data is always valid. A flag can be set only by its event strobe. Software clears a flag in two steps. First it reads the register while that flag shows 1, which arms the flag. Then it writes 0 to that bit position. Every flag also drives its own interrupt request line.

Top module: `tmr_evt_status`

## Requirements
- R1: After reset, and whenever reset is asserted again, `rdata` equals 0x70 and `irq` equals 0.
- R2: A pulse on `ovf_evt` sets bit 7 of `rdata` from the next clock edge on.
- R3: A pulse on `ch_evt[i]` sets bit i of `rdata` from the next clock edge on. Channel A is bit 0, B is bit 1, C is bit 2 and D is bit 3.
- R4: Bits 6 to 4 of `rdata` always read 1, whatever is written to them.
- R5: Writing 1 to a flag bit never sets that flag and never clears it.
- R6: A flag clears at the edge of a write (`sel` and `wr`) that has 0 in its bit position, provided an earlier read (`sel` and `rd` without `wr`) returned that flag as 1.
- R7: A write of 0 to a flag that has not been armed by such a read leaves the flag unchanged.
- R8: Every write disarms all flags, whatever data it carries. After a write, a second write of 0 with no new read clears nothing.
- R9: If an event strobe and a qualifying clear write reach the same flag in the same cycle, the flag stays 1.
- R10: An event on a flag that is already 1 leaves the flag at 1 and keeps its armed state.
- R11: A read that returns a flag as 0 does not arm that flag, even if the flag is set later.
- R12: If read and write are strobed in the same cycle, the write uses the arming from earlier reads and the read arms nothing.
- R13: `irq` equals {bit 7, bits 3..0} of `rdata` in every cycle. Bit 4 of `irq` is the overflow request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| ovf_evt | input | 1 | Counter wrap strobe (0xFFFF to 0x0000) |
| ch_evt | input | 4 | Per-channel compare or capture strobes, bit 0 = A |
| rdata | output | 8 | Register contents |
| irq | output | 5 | Interrupt requests, bit 4 = overflow, bits 3..0 = channels |

## Verification
The assertions check four things on every cycle:
- No flag rises without an event strobe in the cycle before.
- No flag falls without an armed bit and a written 0.
- An event strobe always leaves its flag at 1.
- An armed bit never outlives its flag, and a write always disarms every flag.

Only the bench's scenarios can show the full read-then-write ordering. That covers reads that see a flag as 0, a write that disarms flags before a later zero write, and read and write strobed together. These need the history of several bus cycles, checked against the values seen at the ports.

// File: rtl/tmr_evt_status.sv
module tmr_evt_status #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel,
  input  logic           rd,
  input  logic           wr,
  input  logic [7:0]     wdata,
  input  logic           ovf_evt,
  input  logic [NCH-1:0] ch_evt,
  output logic [7:0]     rdata,
  output logic [NCH:0]   irq
);
  localparam int NF = NCH + 1;

  logic [NF-1:0] flag_q, arm_q, evt_v, wbit, clr_v;
  logic          wr_hit, rd_hit;

  assign evt_v  = {ovf_evt, ch_evt};
  assign wbit   = {wdata[7], wdata[NCH-1:0]};
  assign wr_hit = sel && wr;
  assign rd_hit = sel && rd && !wr;
  assign clr_v  = wr_hit ? (arm_q & ~wbit) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      arm_q  <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_v) | evt_v;
      if (wr_hit)      arm_q <= '0;
      else if (rd_hit) arm_q <= arm_q | flag_q;
    end
  end

  assign rdata = {flag_q[NF-1], 3'b111, flag_q[NCH-1:0]};
  assign irq   = flag_q;

  p_hw_only_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q)) & ~$past(evt_v)) == '0);
  p_clear_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flag_q) & ~flag_q) & ~($past(arm_q) & ~$past(wbit) & {NF{$past(wr_hit)}})) == '0);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_v != '0) |=> ((flag_q & $past(evt_v)) == $past(evt_v)));
  p_arm_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q & ~flag_q) == '0);
  p_wr_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (arm_q == '0));
  p_ones_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && (&wdata)) |=> (($past(flag_q) & ~flag_q) == '0));
endmodule

// File: tb/tmr_evt_status_tb_top.sv
`timescale 1ns/1ps
module tmr_evt_status_tb_top;
  logic clk = 0, rst_n = 0, sel = 0, rd = 0, wr = 0, ovf_evt = 0;
  logic [7:0] wdata = 0;
  logic [3:0] ch_evt = 0;
  logic [7:0] rdata;
  logic [4:0] irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_evt_status dut_i (.clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr),
    .wdata(wdata), .ovf_evt(ovf_evt), .ch_evt(ch_evt), .rdata(rdata), .irq(irq));

  // {sel, rd, wr, wdata, ovf, ch[3:0], expected rdata after the edge}
  localparam int NV = 23;
  localparam logic [23:0] VEC [0:NV-1] = '{
    {3'b000, 8'h00, 1'b0, 4'h0, 8'h70}, // idle R1
    {3'b000, 8'h00, 1'b1, 4'h0, 8'hF0}, // overflow R2
    {3'b000, 8'h00, 1'b0, 4'h1, 8'hF1}, // ch A R3
    {3'b000, 8'h00, 1'b0, 4'h8, 8'hF9}, // ch D R3
    {3'b101, 8'h00, 1'b0, 4'h0, 8'hF9}, // unarmed zero write R7
    {3'b101, 8'hFF, 1'b0, 4'h0, 8'hF9}, // ones write R5 R4
    {3'b110, 8'h00, 1'b0, 4'h0, 8'hF9}, // read arms
    {3'b101, 8'h7F, 1'b0, 4'h0, 8'h79}, // clear ovf R6
    {3'b101, 8'h00, 1'b0, 4'h0, 8'h79}, // disarmed R8
    {3'b110, 8'h00, 1'b0, 4'h0, 8'h79}, // read arms D,A
    {3'b000, 8'h00, 1'b0, 4'h5, 8'h7D}, // re-event A, new C R10
    {3'b101, 8'h00, 1'b0, 4'h0, 8'h74}, // clear D,A, C kept R10
    {3'b110, 8'h00, 1'b0, 4'h0, 8'h74}, // arm C
    {3'b101, 8'h00, 1'b0, 4'h4, 8'h74}, // set wins R9
    {3'b101, 8'h00, 1'b0, 4'h0, 8'h74}, // disarmed R8
    {3'b110, 8'h00, 1'b0, 4'h0, 8'h74}, // arm C
    {3'b111, 8'h00, 1'b0, 4'h0, 8'h70}, // rd+wr uses old arm R12
    {3'b000, 8'h00, 1'b0, 4'h2, 8'h72}, // ch B R3
    {3'b111, 8'h00, 1'b0, 4'h0, 8'h72}, // rd+wr, B unarmed R12
    {3'b101, 8'h00, 1'b0, 4'h0, 8'h72}, // rd+wr did not arm R12
    {3'b110, 8'h00, 1'b0, 4'h0, 8'h72}, // arm B only
    {3'b000, 8'h00, 1'b1, 4'h0, 8'hF2}, // ovf after read R11
    {3'b101, 8'h00, 1'b0, 4'h0, 8'hF0}  // ovf stays, B clears R11
  };

  task automatic chk(input string req, input logic [7:0] exp);
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s rdata actual %h expected %h", req, rdata, exp);
    end
    checks++;
    if (irq !== {exp[7], exp[3:0]}) begin
      errors++;
      $display("FAIL R13 irq actual %h expected %h", irq, {exp[7], exp[3:0]});
    end
  endtask

  task automatic idle();
    {sel, rd, wr, ovf_evt} = '0; wdata = '0; ch_evt = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1", 8'h70);
    @(negedge clk) rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {sel, rd, wr, wdata, ovf_evt, ch_evt} = VEC[i][23:8];
      @(posedge clk); #1;
      chk($sformatf("R2-13 row %0d", i), VEC[i][7:0]);
    end
    @(negedge clk) idle();
    ovf_evt = 1; ch_evt = 4'hF;
    @(posedge clk); #1 chk("R3", 8'hFF);
    @(negedge clk) idle(); sel = 1; wr = 1; wdata = 8'h8F;
    @(posedge clk); #1 chk("R4", 8'hFF);
    @(negedge clk) idle(); rst_n = 0;
    @(posedge clk); #1 chk("R1", 8'h70);
    @(negedge clk) rst_n = 1;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #100000;
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule